// File: doc/BRIEF.md
# Fine Pixel Pan Shifter

This block sits between the pixel serialiser and colour lookup in a raster display pipeline. It takes a stream of pixels and drops a programmed number of leading pixels at the start of each line. The display window can then be panned horizontally in steps finer than one memory address. The width of the step depends on the pixel format. In plain modes one step is one pixel. In the nine-dot text format the programmed count is rotated by one position. In the packed 256-colour format the incoming stream carries 4-bit halves, and the block joins pairs of them into 8-bit output pixels.

The address generator raises a flag when the split line is reached. If the panning-mode input is set, any line that starts after the flag is raised gets no shift, until the next frame begins. The shift, the format and the panning-mode bit are taken once, on the line-start cycle, and are held for the rest of the line. Each output pixel appears one clock after the input pixel that completes it.

Top module: `pan_fine_shift`

## Requirements
- R1: `line_start_i` is high together with the first pixel of a line. Every input pixel that is not discarded produces an output one clock later, in input order, and idle cycles (`pix_valid_i` low) produce no output.
- R2: Format code 0 is the plain format. The low three bits of `shift_i` (0 to 7) give the number of leading pixels discarded, and bit 3 has no effect.
- R3: Format code 1 is the nine-dot text format. A shift of 8 discards nothing, and a value v from 0 to 7 discards v+1 pixels. Values 9 to 15 discard nothing.
- R4: Format code 2 is the packed format. Only the low 4 bits of each input pixel are used. Two successive kept nibbles form one output pixel, with the earlier nibble in bits 7:4. The low three bits of `shift_i` give the number of leading nibbles discarded, so an even value v removes v/2 output pixels.
- R5: In the packed format an odd shift is applied unchanged, not rounded. Each output then joins the second nibble of one source pixel with the first nibble of the next.
- R6: The split flag goes high on `split_hit_i`, including in the same cycle as a line start, and stays high until `frame_start_i`. While the flag is high and `pan_mode_i` is 1 at a line start, that line discards nothing. With `pan_mode_i` at 0 the flag has no effect.
- R7: `shift_i`, `mode_i` and `pan_mode_i` are sampled only on the line-start cycle. Changing them later in the line has no effect on that line.
- R8: While `rst_ni` is low, `pix_valid_o` and `pix_data_o` are 0.
- R9: Format code 3 behaves exactly like format code 0.
- R10: A line start resets the nibble pairing. An unpaired nibble left over from the previous line is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Frame begin pulse; clears the split flag |
| line_start_i | input | 1 | Marks the cycle of the first pixel of a line |
| pix_valid_i | input | 1 | Input pixel present |
| pix_data_i | input | PIX_W | Input pixel (nibble in low bits in packed format) |
| shift_i | input | 4 | Programmed fine shift count |
| mode_i | input | 2 | Format: 0 plain, 1 nine-dot, 2 packed, 3 plain |
| pan_mode_i | input | 1 | 1: no shift on lines after the split |
| split_hit_i | input | 1 | Split line reached, from address generator |
| pix_valid_o | output | 1 | Output pixel present |
| pix_data_o | output | PIX_W | Output pixel |

## Verification
Faults in the internal state appear at the outputs quickly:
- A wrong remaining-discard count shows up as an early or late first output pixel on the line where it occurs.
- A wrong pairing phase or held nibble corrupts the very next packed output, one clock after the nibble that should have completed it.
- A stale split flag changes the first output of the next line.

The bench mirrors the requirements in a behavioural model and compares the outputs on every clock. Any of these faults is therefore reported within one line.

// File: rtl/pan_pkg.sv
package pan_pkg;
  localparam int SHIFT_W = 4;
  localparam int CNT_W   = 4;

  typedef enum logic [1:0] {
    FMT_STD  = 2'd0,
    FMT_DOT9 = 2'd1,
    FMT_WIDE = 2'd2,
    FMT_ALT  = 2'd3
  } pan_fmt_e;
endpackage

// File: rtl/pan_split_track.sv
module pan_split_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  input  logic split_hit_i,
  output logic split_o
);
  logic split_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            split_q <= 1'b0;
    else if (frame_start_i) split_q <= 1'b0;
    else if (split_hit_i)   split_q <= 1'b1;
  end

  // same-cycle hit counts; frame start hides the old flag
  assign split_o = (split_q & ~frame_start_i) | split_hit_i;

  assert_split_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split_hit_i && !frame_start_i) |=> split_q);
  assert_split_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> !split_q);
endmodule

// File: rtl/pan_shift_decode.sv
module pan_shift_decode
  import pan_pkg::*;
(
  input  logic [SHIFT_W-1:0] shift_i,
  input  pan_fmt_e           fmt_i,
  input  logic               pan_mode_i,
  input  logic               split_i,
  output logic [CNT_W-1:0]   drop_o
);
  logic [CNT_W-1:0] raw;

  always_comb begin
    unique case (fmt_i)
      FMT_DOT9: raw = (shift_i <= SHIFT_W'(7)) ? CNT_W'(shift_i) + CNT_W'(1) : '0;
      default:  raw = CNT_W'(shift_i[2:0]);
    endcase
    drop_o = (pan_mode_i && split_i) ? '0 : raw;
  end
endmodule

// File: rtl/pan_drop_ctr.sv
module pan_drop_ctr
  import pan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_start_i,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] drop_i,
  output logic             pass_o
);
  logic [CNT_W-1:0] rem_q, rem_eff;

  always_comb begin
    rem_eff = line_start_i ? drop_i : rem_q;
    pass_o  = valid_i && (rem_eff == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rem_q <= '0;
    else if (valid_i && rem_eff != '0)    rem_q <= rem_eff - CNT_W'(1);
    else                                  rem_q <= rem_eff;
  end

  assert_rem_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q <= CNT_W'(8));
  assert_rem_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !line_start_i && rem_q != '0) |=> (rem_q == $past(rem_q) - CNT_W'(1)));
endmodule

// File: rtl/pan_pack.sv
module pan_pack
  import pan_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_start_i,
  input  pan_fmt_e         fmt_i,
  input  logic             pass_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             valid_o,
  output logic [PIX_W-1:0] data_o
);
  localparam int NIB_W = PIX_W / 2;

  pan_fmt_e         fmt_q, fmt_eff;
  logic             half_q, half_eff, wide;
  logic [NIB_W-1:0] hold_q;

  always_comb begin
    fmt_eff  = line_start_i ? fmt_i : fmt_q;
    half_eff = line_start_i ? 1'b0 : half_q;
    wide     = (fmt_eff == FMT_WIDE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q   <= FMT_STD;
      half_q  <= 1'b0;
      hold_q  <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      fmt_q   <= fmt_eff;
      half_q  <= half_eff;
      valid_o <= 1'b0;
      if (pass_i) begin
        if (!wide) begin
          valid_o <= 1'b1;
          data_o  <= pix_i;
        end else if (!half_eff) begin
          hold_q <= pix_i[NIB_W-1:0];
          half_q <= 1'b1;
        end else begin
          valid_o <= 1'b1;
          data_o  <= {hold_q, pix_i[NIB_W-1:0]};
          half_q  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pan_fine_shift.sv
module pan_fine_shift
  import pan_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic               line_start_i,
  input  logic               pix_valid_i,
  input  logic [PIX_W-1:0]   pix_data_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [1:0]         mode_i,
  input  logic               pan_mode_i,
  input  logic               split_hit_i,
  output logic               pix_valid_o,
  output logic [PIX_W-1:0]   pix_data_o
);
  logic             split;
  logic [CNT_W-1:0] drop;
  logic             pass;
  pan_fmt_e         fmt;

  assign fmt = pan_fmt_e'(mode_i);

  pan_split_track u_split (
    .clk_i, .rst_ni, .frame_start_i, .split_hit_i, .split_o(split)
  );

  pan_shift_decode u_dec (
    .shift_i, .fmt_i(fmt), .pan_mode_i, .split_i(split), .drop_o(drop)
  );

  pan_drop_ctr u_ctr (
    .clk_i, .rst_ni, .line_start_i, .valid_i(pix_valid_i), .drop_i(drop), .pass_o(pass)
  );

  pan_pack #(.PIX_W(PIX_W)) u_pack (
    .clk_i, .rst_ni, .line_start_i, .fmt_i(fmt), .pass_i(pass), .pix_i(pix_data_i),
    .valid_o(pix_valid_o), .data_o(pix_data_o)
  );

  assert_out_cause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> $past(pix_valid_i));
endmodule

// File: tb/tb_pan_fine_shift.sv
`timescale 1ns/1ps
module tb_pan_fine_shift;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fs = 0, ls = 0, vi = 0, pm = 0, sp = 0;
  logic [7:0] di = 0;
  logic [3:0] sh = 0;
  logic [1:0] md = 0;
  logic       vo;
  logic [7:0] dout;

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit done = 0;

  // model state
  int m_rem = 0, m_half = 0, m_hold = 0, m_fmt = 0;
  bit m_split = 0;
  bit exp_v = 0;
  int exp_d = 0;
  int g_pix = 0;

  always #2 clk = ~clk;

  pan_fine_shift dut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_start_i(fs), .line_start_i(ls),
    .pix_valid_i(vi), .pix_data_i(di), .shift_i(sh), .mode_i(md),
    .pan_mode_i(pm), .split_hit_i(sp), .pix_valid_o(vo), .pix_data_o(dout)
  );

  task automatic chk(string req, int got, int expv, string what);
    total++;
    if (got != expv) begin
      bad++;
      $display("FAIL %s %s: got %0h exp %0h", req, what, got, expv);
    end
  endtask

  function automatic int drop_for(int s, int f, bit p, bit split_now);
    if (p && split_now) return 0;
    if (f == 1) return (s <= 7) ? s + 1 : 0;   // R3
    return s % 8;                              // R2, R4, R9
  endfunction

  // compare last expectation, drive one cycle, predict next output
  task automatic step(bit f, bit l, bit v, int d, int s, int mo, bit p, bit h);
    chk(cur_req, vo, exp_v, "valid");
    if (exp_v) chk(cur_req, dout, exp_d, "data");
    fs = f; ls = l; vi = v; di = d[7:0]; sh = s[3:0]; md = mo[1:0]; pm = p; sp = h;
    exp_v = 0;
    if (l) begin
      m_half = 0;
      m_fmt  = mo;
      m_rem  = drop_for(s, mo, p, (m_split && !f) || h);
    end
    if (v) begin
      if (m_rem > 0) m_rem--;
      else if (m_fmt == 2) begin
        if (m_half == 0) begin m_hold = d % 16; m_half = 1; end
        else begin exp_v = 1; exp_d = m_hold * 16 + d % 16; m_half = 0; end
      end else begin exp_v = 1; exp_d = d % 256; end
    end
    if (f) m_split = 0; else if (h) m_split = 1;
    @(negedge clk);
  endtask

  task automatic run_line(int n, int s, int mo, int s2, int mo2, bit p, int split_at, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && i % 4 == 3) step(0, 0, 0, 0, s2, mo2, p, 0);
      step(0, i == 0, 1, g_pix, (i == 0) ? s : s2, (i == 0) ? mo : mo2, p, i == split_at);
      g_pix = (g_pix + 7) % 256;
    end
    step(0, 0, 0, 0, s2, mo2, p, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", vo, 0, "valid in reset");
    chk("R8", dout, 0, "data in reset");
    rst_ni = 1'b1;
    @(negedge clk);

    cur_req = "R2";
    for (int s = 0; s < 16; s++) run_line(12, s, 0, s, 0, 0, -1, s % 2);
    cur_req = "R9";
    for (int s = 0; s < 8; s += 3) run_line(10, s, 3, s, 3, 0, -1, 0);
    cur_req = "R3";
    for (int s = 0; s < 16; s++) run_line(12, s, 1, s, 1, 0, -1, s % 3 == 0);
    cur_req = "R4";
    for (int s = 0; s < 16; s += 2) run_line(14, s, 2, s, 2, 0, -1, s % 4 == 2);
    cur_req = "R5";
    for (int s = 1; s < 8; s += 2) run_line(14, s, 2, s, 2, 0, -1, 0);
    cur_req = "R10";
    run_line(11, 0, 2, 0, 2, 0, -1, 0);
    run_line(11, 1, 2, 1, 2, 0, -1, 0);
    run_line(10, 0, 2, 0, 2, 0, -1, 0);
    cur_req = "R7";
    run_line(12, 2, 0, 5, 2, 0, -1, 0);
    run_line(12, 4, 2, 7, 1, 0, -1, 0);
    run_line(12, 8, 1, 0, 0, 1, -1, 0);
    cur_req = "R6";
    step(1, 0, 0, 0, 5, 0, 1, 0);
    run_line(10, 5, 0, 5, 0, 1, -1, 0);
    run_line(10, 5, 0, 5, 0, 1, 4, 0);
    run_line(10, 5, 0, 5, 0, 1, -1, 0);
    run_line(10, 6, 2, 6, 2, 1, -1, 0);
    run_line(10, 5, 0, 5, 0, 0, -1, 0);
    step(1, 0, 0, 0, 5, 0, 1, 0);
    run_line(10, 5, 0, 5, 0, 1, -1, 0);
    run_line(10, 3, 1, 3, 1, 1, 0, 0);
    run_line(10, 3, 1, 3, 1, 1, -1, 0);
    step(1, 0, 0, 0, 5, 0, 1, 0);
    run_line(10, 3, 1, 3, 1, 1, -1, 0);
    cur_req = "R1";
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R1 watchdog: got 0 exp 1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule